// File: doc/BRIEF.md
# Flash Read-Timing Cycle Calculator

This block converts a flash interface timing mode (0 to 5) into the clock-cycle counts that a flash interface sequencer needs. It is sized for one controller clock period, given in nanoseconds as a parameter. It produces eight counts:

- read/write enable low time
- read/write enable high time
- read data access time
- address-to-data delay
- read-to-write turnaround
- read-to-read turnaround
- write-to-read turnaround
- chip-select setup

The nanosecond limits for each mode sit in an internal constant table. The counts come from ceiling divisions by the clock period. The enable low time, the access time and the chip-select setup are then widened step by step in a small state machine until their margins are met.

A run begins with a one-cycle `start` pulse. The mode is taken either from a 3-bit request or from a capability mask reported by an attached device. When every count is final, the outputs update and `done` pulses for one cycle. Each widening loop is bounded. If a loop reaches its bound, `err` is raised for that run and the counts reached so far are kept.

Limits in ns, one row per mode. The columns are: access (A), enable-low minimum (L), enable-high minimum (H), cycle minimum (C), hold after enable high (OH), hold after enable low (OL), chip-enable access (CE), address-to-data (AD), read-to-write (RW), read turnaround (RR), write-to-read (WR) and chip-select minimum (CS).

| Mode | A | L | H | C | OH | OL | CE | AD | RW | RR | WR | CS |
|---|---|---|---|---|---|---|---|---|---|---|---|---|
| 5 | 16 | 10 | 7 | 20 | 15 | 5 | 25 | 70 | 100 | 100 | 60 | 15 |
| 4 | 20 | 12 | 10 | 25 | 15 | 5 | 25 | 70 | 100 | 100 | 60 | 20 |
| 3 | 20 | 15 | 10 | 30 | 15 | 0 | 25 | 100 | 100 | 100 | 60 | 25 |
| 2 | 25 | 17 | 15 | 35 | 15 | 0 | 30 | 100 | 100 | 100 | 80 | 25 |
| 1 | 30 | 25 | 15 | 50 | 15 | 0 | 45 | 100 | 100 | 100 | 80 | 35 |
| 0 | 40 | 50 | 30 | 100 | 0 | 0 | 100 | 200 | 200 | 200 | 120 | 70 |

Below, P is the parameter `CLK_NS`, ceil(x) means the ceiling of x/P, and M is the parameter `MIN_CYC`.

Top module: `onfi_tcalc`

## Requirements
- R1: After a synchronous reset, all eight counts, `done` and `err` are 0.
- R2: With `use_mask`=0 the mode is `mode_req`. Request values 6 and 7 are treated as mode 5.
- R3: With `use_mask`=1 the mode is the index of the highest set bit of `mode_mask`, whose bits are numbered 5 down to 1. If no bit is set, the mode is 0.
- R4: `lo_cnt` starts at ceil(L) and `hi_cnt` is ceil(H). If (lo+hi)·P < C, lo grows by ceil(C − (lo+hi)·P). If lo+hi < M afterwards, lo becomes M − hi.
- R5: Next, lo is raised by 1 per step while min(lo·P + OH, (lo+hi)·P + OL) − A < 8.
- R6: `acc_cnt` starts at ceil(A) and is raised by 1 per step while acc·P − A < 3.
- R7: `adl_cnt`, `rhw_cnt`, `rhz_cnt` and `whr_cnt` are ceil(AD), ceil(RW), ceil(RR) and ceil(WR).
- R8: `cs_cnt` is ceil(CS − L), forced to at least 1. It is then raised by 1 per step while cs·P + A < CE.
- R9: `done` is high for exactly one cycle per accepted start. All counts and `err` change only in that cycle and hold until the next `done`.
- R10: A `start` that arrives while a run is in progress is ignored. The running result is unchanged and no extra `done` follows.
- R11: Each widening loop (R5, R6, R8) makes at most `LOOP_MAX` increments. A loop that would need more stops there, and `err`=1 is reported with that run. A later run that stays within the bound reports `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a calculation (one-cycle pulse) |
| use_mask | input | 1 | Select mode from `mode_mask` instead of `mode_req` |
| mode_req | input | 3 | Requested mode |
| mode_mask | input | 5 | Supported-mode mask, bits 5..1 |
| lo_cnt | output | CNT_W | Enable low cycles |
| hi_cnt | output | CNT_W | Enable high cycles |
| acc_cnt | output | CNT_W | Read access cycles |
| adl_cnt | output | CNT_W | Address-to-data cycles |
| rhw_cnt | output | CNT_W | Read-to-write cycles |
| rhz_cnt | output | CNT_W | Read-to-read cycles |
| whr_cnt | output | CNT_W | Write-to-read cycles |
| cs_cnt | output | CNT_W | Chip-select setup cycles |
| done | output | 1 | Results valid pulse |
| err | output | 1 | A loop hit its step bound in the latest run |

## Verification
The hardest case to reach from the ports is the loop bound of R11. With a realistic clock period, no mode needs more than a handful of widening steps. The bench therefore runs a second instance beside the main one, with a 1 ns clock period and a bound of three steps. On that instance, mode 0 needs about forty chip-select steps and so overflows, while mode 3 fits within the bound. Going from the first run to the second shows both the raising and the clearing of `err`. The busy case of R10 is reached by raising `start` again, with another mode, on the cycle right after the accepted start.

// File: rtl/onfi_tc_pkg.sv
package onfi_tc_pkg;

  localparam int MODE_TOP = 5;
  localparam int LIM_W    = 8;
  localparam int NS_W     = 16;

  typedef struct packed {
    logic [LIM_W-1:0] rea;
    logic [LIM_W-1:0] rp;
    logic [LIM_W-1:0] reh;
    logic [LIM_W-1:0] rc;
    logic [LIM_W-1:0] rhoh;
    logic [LIM_W-1:0] rloh;
    logic [LIM_W-1:0] cea;
    logic [LIM_W-1:0] adl;
    logic [LIM_W-1:0] rhw;
    logic [LIM_W-1:0] rhz;
    logic [LIM_W-1:0] whr;
    logic [LIM_W-1:0] cs;
  } onfi_lim_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RC, ST_MINC, ST_DV, ST_ACC, ST_CS, ST_FIN
  } tc_state_e;

  function automatic logic [NS_W-1:0] ceil_div(input logic [NS_W-1:0] num,
                                               input logic [NS_W-1:0] den);
    return (num + den - NS_W'(1)) / den;
  endfunction

endpackage

// File: rtl/onfi_tc_rom.sv
module onfi_tc_rom
  import onfi_tc_pkg::*;
(
  input  logic [2:0] mode,
  output onfi_lim_t  lim
);

  always_comb begin
    case (mode)
      3'd0:    lim = '{8'd40, 8'd50, 8'd30, 8'd100, 8'd0,  8'd0, 8'd100, 8'd200, 8'd200, 8'd200, 8'd120, 8'd70};
      3'd1:    lim = '{8'd30, 8'd25, 8'd15, 8'd50,  8'd15, 8'd0, 8'd45,  8'd100, 8'd100, 8'd100, 8'd80,  8'd35};
      3'd2:    lim = '{8'd25, 8'd17, 8'd15, 8'd35,  8'd15, 8'd0, 8'd30,  8'd100, 8'd100, 8'd100, 8'd80,  8'd25};
      3'd3:    lim = '{8'd20, 8'd15, 8'd10, 8'd30,  8'd15, 8'd0, 8'd25,  8'd100, 8'd100, 8'd100, 8'd60,  8'd25};
      3'd4:    lim = '{8'd20, 8'd12, 8'd10, 8'd25,  8'd15, 8'd5, 8'd25,  8'd70,  8'd100, 8'd100, 8'd60,  8'd20};
      default: lim = '{8'd16, 8'd10, 8'd7,  8'd20,  8'd15, 8'd5, 8'd25,  8'd70,  8'd100, 8'd100, 8'd60,  8'd15};
    endcase
  end

endmodule

// File: rtl/onfi_tc_mode.sv
module onfi_tc_mode
  import onfi_tc_pkg::*;
(
  input  logic                  use_mask,
  input  logic [2:0]            req,
  input  logic [MODE_TOP:1]     mask,
  output logic [2:0]            mode
);

  always_comb begin
    mode = 3'd0;
    if (use_mask) begin
      for (int b = 1; b <= MODE_TOP; b++)
        if (mask[b]) mode = 3'(b);
    end else begin
      mode = (req > 3'(MODE_TOP)) ? 3'(MODE_TOP) : req;
    end
  end

endmodule

// File: rtl/onfi_tcalc.sv
module onfi_tcalc
  import onfi_tc_pkg::*;
#(
  parameter int CLK_NS   = 5,
  parameter int MIN_CYC  = 4,
  parameter int LOOP_MAX = 64,
  parameter int CNT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 use_mask,
  input  logic [2:0]           mode_req,
  input  logic [MODE_TOP:1]    mode_mask,
  output logic [CNT_W-1:0]     lo_cnt,
  output logic [CNT_W-1:0]     hi_cnt,
  output logic [CNT_W-1:0]     acc_cnt,
  output logic [CNT_W-1:0]     adl_cnt,
  output logic [CNT_W-1:0]     rhw_cnt,
  output logic [CNT_W-1:0]     rhz_cnt,
  output logic [CNT_W-1:0]     whr_cnt,
  output logic [CNT_W-1:0]     cs_cnt,
  output logic                 done,
  output logic                 err
);

  localparam int STEP_W = $clog2(LOOP_MAX + 1);
  localparam logic [NS_W-1:0] CK = NS_W'(CLK_NS);

  tc_state_e        state;
  logic [2:0]       pick_mode, mode_q;
  onfi_lim_t        lim;
  logic [CNT_W-1:0] lo, hi, acc, adl, rhw, rhz, whr, cs;
  logic [STEP_W-1:0] steps;
  logic             err_w;

  onfi_tc_mode u_mode (
    .use_mask (use_mask),
    .req      (mode_req),
    .mask     (mode_mask),
    .mode     (pick_mode)
  );

  onfi_tc_rom u_rom (
    .mode (mode_q),
    .lim  (lim)
  );

  // Working arithmetic on the current counts
  logic [NS_W-1:0] lo_ns, cyc_ns, oh_end, ol_end, dv_end, cs_raw;
  logic            dv_short, acc_short, cs_short, step_full;

  always_comb begin
    lo_ns     = NS_W'(lo) * CK;
    cyc_ns    = (NS_W'(lo) + NS_W'(hi)) * CK;
    oh_end    = lo_ns + NS_W'(lim.rhoh);
    ol_end    = cyc_ns + NS_W'(lim.rloh);
    dv_end    = (oh_end < ol_end) ? oh_end : ol_end;
    dv_short  = dv_end < (NS_W'(lim.rea) + NS_W'(8));
    acc_short = (NS_W'(acc) * CK) < (NS_W'(lim.rea) + NS_W'(3));
    cs_short  = (NS_W'(cs) * CK + NS_W'(lim.rea)) < NS_W'(lim.cea);
    step_full = (steps == STEP_W'(LOOP_MAX));
    cs_raw    = (lim.cs > lim.rp) ? ceil_div(NS_W'(lim.cs - lim.rp), CK) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= '0;
      lo      <= '0;
      hi      <= '0;
      acc     <= '0;
      adl     <= '0;
      rhw     <= '0;
      rhz     <= '0;
      whr     <= '0;
      cs      <= '0;
      steps   <= '0;
      err_w   <= 1'b0;
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      acc_cnt <= '0;
      adl_cnt <= '0;
      rhw_cnt <= '0;
      rhz_cnt <= '0;
      whr_cnt <= '0;
      cs_cnt  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= pick_mode;
            err_w  <= 1'b0;
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          lo    <= CNT_W'(ceil_div(NS_W'(lim.rp),  CK));
          hi    <= CNT_W'(ceil_div(NS_W'(lim.reh), CK));
          acc   <= CNT_W'(ceil_div(NS_W'(lim.rea), CK));
          adl   <= CNT_W'(ceil_div(NS_W'(lim.adl), CK));
          rhw   <= CNT_W'(ceil_div(NS_W'(lim.rhw), CK));
          rhz   <= CNT_W'(ceil_div(NS_W'(lim.rhz), CK));
          whr   <= CNT_W'(ceil_div(NS_W'(lim.whr), CK));
          cs    <= (cs_raw == '0) ? CNT_W'(1) : CNT_W'(cs_raw);
          state <= ST_RC;
        end
        ST_RC: begin
          if (cyc_ns < NS_W'(lim.rc))
            lo <= lo + CNT_W'(ceil_div(NS_W'(lim.rc) - cyc_ns, CK));
          state <= ST_MINC;
        end
        ST_MINC: begin
          if ((NS_W'(lo) + NS_W'(hi)) < NS_W'(MIN_CYC))
            lo <= CNT_W'(MIN_CYC) - hi;
          steps <= '0;
          state <= ST_DV;
        end
        ST_DV: begin
          if (dv_short && !step_full) begin
            lo    <= lo + CNT_W'(1);
            steps <= steps + STEP_W'(1);
          end else begin
            if (dv_short) err_w <= 1'b1;
            steps <= '0;
            state <= ST_ACC;
          end
        end
        ST_ACC: begin
          if (acc_short && !step_full) begin
            acc   <= acc + CNT_W'(1);
            steps <= steps + STEP_W'(1);
          end else begin
            if (acc_short) err_w <= 1'b1;
            steps <= '0;
            state <= ST_CS;
          end
        end
        ST_CS: begin
          if (cs_short && !step_full) begin
            cs    <= cs + CNT_W'(1);
            steps <= steps + STEP_W'(1);
          end else begin
            if (cs_short) err_w <= 1'b1;
            steps <= '0;
            state <= ST_FIN;
          end
        end
        default: begin
          lo_cnt  <= lo;
          hi_cnt  <= hi;
          acc_cnt <= acc;
          adl_cnt <= adl;
          rhw_cnt <= rhw;
          rhz_cnt <= rhz;
          whr_cnt <= whr;
          cs_cnt  <= cs;
          err     <= err_w;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  // Data-valid end computed from the published counts, for checking
  logic [NS_W-1:0] out_oh, out_ol, out_dv;
  always_comb begin
    out_oh = NS_W'(lo_cnt) * CK + NS_W'(lim.rhoh);
    out_ol = (NS_W'(lo_cnt) + NS_W'(hi_cnt)) * CK + NS_W'(lim.rloh);
    out_dv = (out_oh < out_ol) ? out_oh : out_ol;
  end

  assert_mode_range_R2: assert property (@(posedge clk) disable iff (rst)
    mode_q <= 3'(MODE_TOP));

  assert_min_cycles_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (NS_W'(lo_cnt) + NS_W'(hi_cnt)) >= NS_W'(MIN_CYC));

  assert_window_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> out_dv >= (NS_W'(lim.rea) + NS_W'(8)));

  assert_acc_margin_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (NS_W'(acc_cnt) * CK) >= (NS_W'(lim.rea) + NS_W'(3)));

  assert_cs_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> cs_cnt != '0);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(lo_cnt) && $stable(acc_cnt) && $stable(cs_cnt) && $stable(err)));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> mode_q == $past(mode_q));

endmodule

// File: tb/onfi_tcalc_tb.sv
module onfi_tcalc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CK_A   = 5;
  localparam int LIM_A  = 64;
  localparam int CK_B   = 1;
  localparam int LIM_B  = 3;
  localparam int MINC   = 4;
  localparam int CNT_W  = 8;

  typedef int res_t [9];

  // Limits per mode, indexed by mode
  int T_A  [6] = '{40, 30, 25, 20, 20, 16};
  int T_L  [6] = '{50, 25, 17, 15, 12, 10};
  int T_H  [6] = '{30, 15, 15, 10, 10, 7};
  int T_C  [6] = '{100, 50, 35, 30, 25, 20};
  int T_OH [6] = '{0, 15, 15, 15, 15, 15};
  int T_OL [6] = '{0, 0, 0, 0, 5, 5};
  int T_CE [6] = '{100, 45, 30, 25, 25, 25};
  int T_AD [6] = '{200, 100, 100, 100, 70, 70};
  int T_RW [6] = '{200, 100, 100, 100, 100, 100};
  int T_RR [6] = '{200, 100, 100, 100, 100, 100};
  int T_WR [6] = '{120, 80, 80, 60, 60, 60};
  int T_CS [6] = '{70, 35, 25, 25, 20, 15};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic use_mask = 1'b0;
  logic [2:0] mode_req = '0;
  logic [5:1] mode_mask = '0;

  logic [CNT_W-1:0] a_lo, a_hi, a_acc, a_adl, a_rhw, a_rhz, a_whr, a_cs;
  logic [CNT_W-1:0] b_lo, b_hi, b_acc, b_adl, b_rhw, b_rhz, b_whr, b_cs;
  logic a_done, a_err, b_done, b_err;

  int checks = 0;
  int fails  = 0;
  int got_a  = 0;
  int got_b  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onfi_tcalc #(.CLK_NS(CK_A), .MIN_CYC(MINC), .LOOP_MAX(LIM_A), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .use_mask(use_mask),
    .mode_req(mode_req), .mode_mask(mode_mask),
    .lo_cnt(a_lo), .hi_cnt(a_hi), .acc_cnt(a_acc), .adl_cnt(a_adl),
    .rhw_cnt(a_rhw), .rhz_cnt(a_rhz), .whr_cnt(a_whr), .cs_cnt(a_cs),
    .done(a_done), .err(a_err));

  onfi_tcalc #(.CLK_NS(CK_B), .MIN_CYC(MINC), .LOOP_MAX(LIM_B), .CNT_W(CNT_W)) u_dut_fine (
    .clk(clk), .rst(rst), .start(start), .use_mask(use_mask),
    .mode_req(mode_req), .mode_mask(mode_mask),
    .lo_cnt(b_lo), .hi_cnt(b_hi), .acc_cnt(b_acc), .adl_cnt(b_adl),
    .rhw_cnt(b_rhw), .rhz_cnt(b_rhz), .whr_cnt(b_whr), .cs_cnt(b_cs),
    .done(b_done), .err(b_err));

  function automatic res_t live_a();
    return '{int'(a_lo), int'(a_hi), int'(a_acc), int'(a_adl), int'(a_rhw),
             int'(a_rhz), int'(a_whr), int'(a_cs), int'(a_err)};
  endfunction

  function automatic res_t live_b();
    return '{int'(b_lo), int'(b_hi), int'(b_acc), int'(b_adl), int'(b_rhw),
             int'(b_rhz), int'(b_whr), int'(b_cs), int'(b_err)};
  endfunction

  always @(negedge clk) begin
    if (a_done) got_a++;
    if (b_done) got_b++;
  end

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imin(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  // Expected counts from the requirements
  function automatic res_t model(input int m, input int ck, input int lim);
    res_t r;
    int lo, hi, acc, cs, n, e;
    e  = 0;
    lo = cdiv(T_L[m], ck);
    hi = cdiv(T_H[m], ck);
    if ((lo + hi) * ck < T_C[m]) lo += cdiv(T_C[m] - (lo + hi) * ck, ck);
    if (lo + hi < MINC) lo = MINC - hi;
    n = 0;
    while (imin(lo * ck + T_OH[m], (lo + hi) * ck + T_OL[m]) - T_A[m] < 8) begin
      if (n == lim) begin e = 1; break; end
      lo++; n++;
    end
    acc = cdiv(T_A[m], ck);
    n = 0;
    while (acc * ck - T_A[m] < 3) begin
      if (n == lim) begin e = 1; break; end
      acc++; n++;
    end
    cs = (T_CS[m] > T_L[m]) ? cdiv(T_CS[m] - T_L[m], ck) : 0;
    if (cs == 0) cs = 1;
    n = 0;
    while (cs * ck + T_A[m] < T_CE[m]) begin
      if (n == lim) begin e = 1; break; end
      cs++; n++;
    end
    r = '{lo, hi, acc, cdiv(T_AD[m], ck), cdiv(T_RW[m], ck),
          cdiv(T_RR[m], ck), cdiv(T_WR[m], ck), cs, e};
    return r;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string req, input string inst, input res_t act, input res_t exp);
    chk({req, "/R4"},  {inst, " lo"},  act[0], exp[0]);
    chk({req, "/R4"},  {inst, " hi"},  act[1], exp[1]);
    chk({req, "/R6"},  {inst, " acc"}, act[2], exp[2]);
    chk({req, "/R7"},  {inst, " adl"}, act[3], exp[3]);
    chk({req, "/R7"},  {inst, " rhw"}, act[4], exp[4]);
    chk({req, "/R7"},  {inst, " rhz"}, act[5], exp[5]);
    chk({req, "/R7"},  {inst, " whr"}, act[6], exp[6]);
    chk({req, "/R8"},  {inst, " cs"},  act[7], exp[7]);
    chk({req, "/R11"}, {inst, " err"}, act[8], exp[8]);
  endtask

  task automatic wait_both(input int ga0, input int gb0);
    while (got_a == ga0 || got_b == gb0) @(negedge clk);
  endtask

  // One accepted run: drive, wait for both results, compare, check the hold
  task automatic run_case(input string req, input logic sel, input logic [2:0] m,
                          input logic [5:1] mask, input int eff);
    int ga0, gb0;
    res_t ra, rb;
    ga0 = got_a; gb0 = got_b;
    @(negedge clk);
    use_mask = sel; mode_req = m; mode_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_both(ga0, gb0);
    ra = live_a(); rb = live_b();
    cmp_all(req, "a", ra, model(eff, CK_A, LIM_A));
    cmp_all(req, "b", rb, model(eff, CK_B, LIM_B));
    repeat (6) @(negedge clk);
    chk("R9", "a hold lo", int'(a_lo), ra[0]);
    chk("R9", "a hold cs", int'(a_cs), ra[7]);
    chk("R9", "b hold acc", int'(b_acc), rb[2]);
    chk("R9", "a single done", got_a - ga0, 1);
  endtask

  task automatic t_reset();
    chk("R1", "lo", int'(a_lo), 0);
    chk("R1", "acc", int'(a_acc), 0);
    chk("R1", "cs", int'(a_cs), 0);
    chk("R1", "adl", int'(a_adl), 0);
    chk("R1", "done", int'(a_done), 0);
    chk("R1", "err", int'(a_err), 0);
  endtask

  task automatic t_direct();
    for (int m = 0; m <= 5; m++) run_case("R2", 1'b0, 3'(m), 5'b10101, m);
    run_case("R2", 1'b0, 3'd6, 5'b00000, 5);
    run_case("R2", 1'b0, 3'd7, 5'b00000, 5);
  endtask

  task automatic t_mask();
    run_case("R3", 1'b1, 3'd5, 5'b00101, 3);
    run_case("R3", 1'b1, 3'd5, 5'b00000, 0);
    run_case("R3", 1'b1, 3'd0, 5'b11111, 5);
    run_case("R3", 1'b1, 3'd0, 5'b00011, 2);
  endtask

  task automatic t_busy();
    int ga0, gb0;
    ga0 = got_a; gb0 = got_b;
    @(negedge clk);
    use_mask = 1'b0; mode_req = 3'd0; start = 1'b1;
    @(negedge clk);
    mode_req = 3'd5;
    @(negedge clk);
    start = 1'b0;
    wait_both(ga0, gb0);
    cmp_all("R10", "a", live_a(), model(0, CK_A, LIM_A));
    repeat (100) @(negedge clk);
    chk("R10", "a done count", got_a - ga0, 1);
    chk("R10", "b done count", got_b - gb0, 1);
  endtask

  task automatic t_bound();
    run_case("R11", 1'b0, 3'd0, 5'b00000, 0);
    chk("R11", "b err raised", int'(b_err), 1);
    run_case("R11", 1'b0, 3'd3, 5'b00000, 3);
    chk("R11", "b err cleared", int'(b_err), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_mask();
    t_busy();
    t_bound();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule